// File: doc/BRIEF.md
# Write-once snooping coherence controller

This block is the coherence engine of one small direct-mapped write-back cache on a shared, snooped bus. Every line holds a tag, a two-bit coherence state and a single data word. The controller takes one processor read or write at a time. It answers hits locally and turns misses and shared writes into bus transactions. It also watches transactions that other caches place on the bus and adjusts its own lines to match.

The protocol follows the write-once rule. The first processor write to a clean shared line is written through to memory, and that bus write invalidates every other copy. The line then becomes the sole clean copy. Later writes stay in the cache and mark the line modified. The bus has no ownership read and no invalidate-only command. When another cache reads a line that this cache holds modified, the snoop reply flags a pending write-back and presents the line data in the same cycle. The memory side stores that data before it completes the stalled read. Arbitration, main memory and multi-word lines are outside the block.

Back-pressure rules: the processor request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` is high only while no request is in progress. A response waits with `cpu_rsp_valid` high, and its data held, until `cpu_rsp_ready` is seen high. The bus master keeps `bus_req`, address and write data steady until it sees a cycle with both `bus_gnt` and `bus_ack` high.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, and `bus_req` and `cpu_rsp_valid` are 0. The first access to any address therefore misses. Line state codes are Invalid=00, Valid=01, Reserved=10, Dirty=11. The line index is the low `IDX_W` address bits and the tag is the remaining upper bits.
- R2: A processor read that hits returns the stored word and issues no bus transaction. The line state does not change.
- R3: A processor read that misses issues a bus read (`bus_cmd`=01) of the requested address. It installs the returned word as Valid and returns that word.
- R4: A snooped read (`snp_cmd`=01) to a line held Dirty raises `snp_hit` and `snp_wb_pend` in the same cycle, with `snp_wb_data` equal to the line word. The line then becomes Valid.
- R5: A snooped read to a line held Reserved raises `snp_hit` without `snp_wb_pend`, and the line becomes Valid.
- R6: A processor write that hits a Dirty or Reserved line updates only the stored word. It issues no bus transaction and leaves the line Dirty.
- R7: A processor write that hits a Valid line issues a bus write-through (`bus_cmd`=10) carrying the address and the new word. The line becomes Reserved.
- R8: A snooped write-through (10) or write-back (11) to a held line raises `snp_hit` and makes the line Invalid. `snp_hit` and `snp_wb_pend` stay 0 for lines not held and while `snp_valid` is 0.
- R9: A processor write miss runs as a bus read followed by a write-through of the new word, and the line ends Reserved.
- R10: A miss whose victim line is Dirty first issues a bus write-back (11) of the victim's address and word, then the read. A victim in Invalid, Valid or Reserved is dropped with no bus transaction.
- R11: `bus_req` is held, with `bus_addr` and `bus_wdata` stable, until a cycle with `bus_gnt` and `bus_ack` both high. `bus_cmd` is 00 in every cycle without `bus_gnt`.
- R12: `cpu_req_ready` is high only while idle. A pending response keeps `cpu_rsp_valid` high and `cpu_rsp_rdata` stable until `cpu_rsp_ready` is seen. For writes, the response carries the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller idle, request accepted |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | Response present |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W | Read word, or the written word |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_cmd | output | 2 | 00 none, 01 read, 10 write-through, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Word for write-through or write-back |
| bus_rdata | input | DATA_W | Memory word for a read, valid with ack |
| bus_ack | input | 1 | Memory completes the current transaction |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 2 | Its command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Its address |
| snp_hit | output | 1 | This cache holds the snooped line |
| snp_wb_pend | output | 1 | Snooped read must wait for this cache's write-back |
| snp_wb_data | output | DATA_W | Word to be written back |

## Verification
The assertions rely on the environment. `bus_ack` only comes while `bus_gnt` is high. Each snoop describes a transaction by another cache and never coincides with this cache's own granted transaction. The bench makes sure of both: it grants and acknowledges only in reply to `bus_req`, and it drives snoops only between processor operations. A reference model follows line states and memory contents. From that model it predicts every bus transaction, response word and snoop reply.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_VAL = 2'b01,
    LS_RSV = 2'b10,
    LS_DRT = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'b00,
    BC_READ  = 2'b01,
    BC_WTHRU = 2'b10,
    BC_WBACK = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE   = 2'b00,
    F_DECIDE = 2'b01,
    F_BUS    = 2'b10,
    F_RESP   = 2'b11
  } fsm_st_e;
endpackage

// File: rtl/wo_line_store.sv
module wo_line_store
  import wo_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_e          b_st,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  line_st_e          wr_st,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sn_en,
  input  logic [IDX_W-1:0]  sn_idx,
  input  line_st_e          sn_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  line_st_e          st_q  [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  // Core updates win over snoop updates; the core never writes the
  // index a snoop is touching in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= LS_INV;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          tag_q[i] <= wr_tag;
          st_q[i]  <= wr_st;
          dat_q[i] <= wr_data;
        end else if (sn_en && sn_idx == IDX_W'(i)) begin
          st_q[i] <= sn_st;
        end
      end
    end
  end

  assign a_tag  = tag_q[a_idx];
  assign a_st   = st_q[a_idx];
  assign a_data = dat_q[a_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_st   = st_q[b_idx];
  assign b_data = dat_q[b_idx];
endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
  import wo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  b_idx,
  input  logic [TAG_W-1:0]  b_tag,
  input  line_st_e          b_st,
  input  logic [DATA_W-1:0] b_data,
  output logic              snp_hit,
  output logic              snp_wb_pend,
  output logic [DATA_W-1:0] snp_wb_data,
  output logic              sn_en,
  output logic [IDX_W-1:0]  sn_idx,
  output line_st_e          sn_st
);
  logic held;

  assign b_idx  = snp_addr[IDX_W-1:0];
  assign sn_idx = snp_addr[IDX_W-1:0];
  assign held   = (b_st != LS_INV) && (b_tag == snp_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    snp_hit     = snp_valid && held;
    snp_wb_pend = 1'b0;
    sn_en       = 1'b0;
    sn_st       = b_st;
    if (snp_hit) begin
      unique case (bus_cmd_e'(snp_cmd))
        BC_READ: begin
          if (b_st == LS_DRT || b_st == LS_RSV) begin
            sn_en = 1'b1;
            sn_st = LS_VAL;
          end
          snp_wb_pend = (b_st == LS_DRT);
        end
        BC_WTHRU, BC_WBACK: begin
          sn_en = 1'b1;
          sn_st = LS_INV;
        end
        default: ;
      endcase
    end
  end

  assign snp_wb_data = snp_wb_pend ? b_data : '0;
endmodule

// File: rtl/wo_ctrl_fsm.sv
module wo_ctrl_fsm
  import wo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              snp_valid,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic [IDX_W-1:0]  a_idx,
  input  logic [TAG_W-1:0]  a_tag,
  input  line_st_e          a_st,
  input  logic [DATA_W-1:0] a_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output line_st_e          wr_st,
  output logic [DATA_W-1:0] wr_data
);
  fsm_st_e           fst, fst_d;
  logic              op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [DATA_W-1:0] rsp_q, rsp_d;
  logic              rsp_ld;
  bus_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] baddr_q, baddr_d;
  logic [DATA_W-1:0] bdata_q, bdata_d;
  logic              cmd_ld;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, clash, xfer_done;

  assign idx       = op_addr[IDX_W-1:0];
  assign tag       = op_addr[ADDR_W-1:IDX_W];
  assign a_idx     = idx;
  assign wr_idx    = idx;
  assign hit       = (a_st != LS_INV) && (a_tag == tag);
  assign clash     = snp_valid && (snp_idx == idx);
  assign xfer_done = bus_gnt && bus_ack;

  always_comb begin
    fst_d   = fst;
    wr_en   = 1'b0;
    wr_tag  = a_tag;
    wr_st   = a_st;
    wr_data = a_data;
    rsp_ld  = 1'b0;
    rsp_d   = a_data;
    cmd_ld  = 1'b0;
    cmd_d   = BC_READ;
    baddr_d = op_addr;
    bdata_d = op_wdata;
    unique case (fst)
      F_IDLE: if (cpu_req_valid) fst_d = F_DECIDE;
      F_DECIDE: begin
        // A snoop touching this index wins the cycle; decide next cycle.
        if (!clash) begin
          if (hit && !op_wr) begin
            rsp_ld = 1'b1;
            fst_d  = F_RESP;
          end else if (hit && (a_st == LS_DRT || a_st == LS_RSV)) begin
            wr_en   = 1'b1;
            wr_st   = LS_DRT;
            wr_data = op_wdata;
            rsp_ld  = 1'b1;
            rsp_d   = op_wdata;
            fst_d   = F_RESP;
          end else if (hit) begin
            cmd_ld = 1'b1;
            cmd_d  = BC_WTHRU;
            fst_d  = F_BUS;
          end else if (a_st == LS_DRT) begin
            cmd_ld  = 1'b1;
            cmd_d   = BC_WBACK;
            baddr_d = {a_tag, idx};
            bdata_d = a_data;
            fst_d   = F_BUS;
          end else begin
            cmd_ld  = 1'b1;
            cmd_d   = BC_READ;
            bdata_d = '0;
            fst_d   = F_BUS;
          end
        end
      end
      F_BUS: begin
        if (xfer_done) begin
          unique case (cmd_q)
            BC_READ: begin
              wr_en   = 1'b1;
              wr_tag  = tag;
              wr_st   = LS_VAL;
              wr_data = bus_rdata;
              fst_d   = F_DECIDE;
            end
            BC_WTHRU: begin
              wr_en   = 1'b1;
              wr_tag  = tag;
              wr_st   = LS_RSV;
              wr_data = op_wdata;
              rsp_ld  = 1'b1;
              rsp_d   = op_wdata;
              fst_d   = F_RESP;
            end
            default: begin
              wr_en = 1'b1;
              wr_st = LS_INV;
              fst_d = F_DECIDE;
            end
          endcase
        end
      end
      F_RESP: if (cpu_rsp_ready) fst_d = F_IDLE;
      default: fst_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst      <= F_IDLE;
      op_wr    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      rsp_q    <= '0;
      cmd_q    <= BC_NONE;
      baddr_q  <= '0;
      bdata_q  <= '0;
    end else begin
      fst <= fst_d;
      if (fst == F_IDLE && cpu_req_valid) begin
        op_wr    <= cpu_req_write;
        op_addr  <= cpu_req_addr;
        op_wdata <= cpu_req_wdata;
      end
      if (rsp_ld) rsp_q <= rsp_d;
      if (cmd_ld) begin
        cmd_q   <= cmd_d;
        baddr_q <= baddr_d;
        bdata_q <= bdata_d;
      end
    end
  end

  assign cpu_req_ready = (fst == F_IDLE);
  assign cpu_rsp_valid = (fst == F_RESP);
  assign cpu_rsp_rdata = rsp_q;
  assign bus_req       = (fst == F_BUS);
  assign bus_cmd       = (bus_req && bus_gnt) ? cmd_q : BC_NONE;
  assign bus_addr      = baddr_q;
  assign bus_wdata     = bdata_q;
endmodule

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl
  import wo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_wb_pend,
  output logic [DATA_W-1:0] snp_wb_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx, wr_idx, sn_idx;
  logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
  line_st_e          a_st, b_st, wr_st, sn_st;
  logic [DATA_W-1:0] a_data, b_data, wr_data;
  logic              wr_en, sn_en;

  wo_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
    .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_st(wr_st), .wr_data(wr_data),
    .sn_en(sn_en), .sn_idx(sn_idx), .sn_st(sn_st)
  );

  wo_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
    .snp_hit(snp_hit), .snp_wb_pend(snp_wb_pend), .snp_wb_data(snp_wb_data),
    .sn_en(sn_en), .sn_idx(sn_idx), .sn_st(sn_st)
  );

  wo_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_idx(snp_addr[IDX_W-1:0]),
    .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_st(wr_st),
    .wr_data(wr_data)
  );
endmodule

// File: rtl/wo_coherence_ctrl_chk.sv
module wo_coherence_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_ack,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_hit,
  input logic              snp_wb_pend
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(bus_gnt && bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)); // R11

  AST_CMD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'b00) |-> (bus_gnt && bus_req)); // R11

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata)); // R12

  AST_RSP_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && cpu_rsp_ready |=> cpu_req_ready && !cpu_rsp_valid); // R12

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !cpu_rsp_valid && !bus_req); // R12

  AST_PEND_ON_READ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb_pend |-> snp_hit && snp_valid && (snp_cmd == 2'b01)); // R4

  AST_SNOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> !snp_hit && !snp_wb_pend); // R8
endmodule

bind wo_coherence_ctrl wo_coherence_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_hit(snp_hit),
  .snp_wb_pend(snp_wb_pend)
);

// File: tb/wo_coherence_ctrl_test.sv
`timescale 1ns/1ps
module wo_coherence_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic cpu_rsp_ready = 1'b0;
  logic [DW-1:0] cpu_rsp_rdata;
  logic bus_req;
  logic bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic snp_hit, snp_wb_pend;
  logic [DW-1:0] snp_wb_data;

  int total = 0;
  int bad = 0;

  wo_coherence_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2)) uut (.*);

  always #2.5 clk = ~clk;

  // Reference model: per-index tag/state/word and a sparse memory.
  int m_tag [4];
  int m_st  [4];
  int m_dat [4];
  int mem [int];
  typedef struct { int cmd; int addr; int data; } xact_t;
  xact_t expq [$];

  function automatic int memv(int a);
    if (mem.exists(a)) return mem[a];
    return (a * 97 + 13) & 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every clock: no command without grant, snoop replies quiet when idle.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (!bus_gnt) chk(bus_cmd == 2'b00, "R11", "cmd without grant", bus_cmd, 0);
      if (!snp_valid) chk(!snp_hit && !snp_wb_pend, "R8", "snoop reply idle", {snp_hit, snp_wb_pend}, 0);
    end
  end

  task automatic plan(bit wr, int addr, int wd, output int exp_rd);
    int idx = addr & 3;
    int tg = addr >> 2;
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    if (!hit) begin
      if (m_st[idx] == 3) begin
        expq.push_back('{3, (m_tag[idx] << 2) | idx, m_dat[idx]});
        mem[(m_tag[idx] << 2) | idx] = m_dat[idx];
      end
      expq.push_back('{1, addr, memv(addr)});
      m_tag[idx] = tg; m_st[idx] = 1; m_dat[idx] = memv(addr);
    end
    if (!wr) exp_rd = m_dat[idx];
    else if (m_st[idx] == 1) begin
      expq.push_back('{2, addr, wd});
      mem[addr] = wd; m_st[idx] = 2; m_dat[idx] = wd; exp_rd = wd;
    end else begin
      m_st[idx] = 3; m_dat[idx] = wd; exp_rd = wd;
    end
  endtask

  task automatic cpu_op(bit wr, int addr, int wd, int gnt_delay, int rsp_hold, string req);
    int exp_rd, cycles, wait_cnt, hold_cnt;
    bit done;
    logic [DW-1:0] held_val;
    plan(wr, addr, wd, exp_rd);
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R12", "ready when idle", cpu_req_ready, 1);
    cpu_req_valid = 1'b1; cpu_req_write = wr;
    cpu_req_addr = AW'(addr); cpu_req_wdata = DW'(wd);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(cpu_req_ready == 1'b0, "R12", "busy after accept", cpu_req_ready, 0);
    done = 0; cycles = 0; wait_cnt = 0; hold_cnt = 0; held_val = '0;
    while (!done && cycles < 300) begin
      @(negedge clk);
      cycles++;
      if (bus_gnt) begin
        if (!bus_ack) begin
          if (expq.size() == 0) begin
            chk(0, req, "unexpected bus command", bus_cmd, 0);
          end else begin
            chk(bus_cmd == 2'(expq[0].cmd), req, "bus command", bus_cmd, expq[0].cmd);
            chk(bus_addr == AW'(expq[0].addr), req, "bus address", bus_addr, expq[0].addr);
            if (expq[0].cmd != 1)
              chk(bus_wdata == DW'(expq[0].data), req, "bus write word", bus_wdata, expq[0].data);
            bus_rdata = (expq[0].cmd == 1) ? DW'(expq[0].data) : '0;
          end
          bus_ack = 1'b1;
        end else begin
          if (expq.size() != 0) void'(expq.pop_front());
          bus_gnt = 1'b0; bus_ack = 1'b0;
        end
      end else if (bus_req) begin
        if (wait_cnt < gnt_delay) begin
          wait_cnt++;
          chk(bus_req == 1'b1, "R11", "request held before grant", bus_req, 1);
        end else begin
          wait_cnt = 0; bus_gnt = 1'b1;
        end
      end
      if (cpu_rsp_ready) begin
        cpu_rsp_ready = 1'b0; done = 1;
        chk(cpu_rsp_valid == 1'b0 && cpu_req_ready == 1'b1, "R12", "idle after response",
            {cpu_rsp_valid, cpu_req_ready}, 1);
      end else if (cpu_rsp_valid) begin
        if (hold_cnt > 0)
          chk(cpu_rsp_rdata == held_val, "R12", "response held under back-pressure",
              cpu_rsp_rdata, held_val);
        held_val = cpu_rsp_rdata;
        if (hold_cnt < rsp_hold) hold_cnt++;
        else begin
          chk(cpu_rsp_rdata == DW'(exp_rd), req, "response word", cpu_rsp_rdata, exp_rd);
          cpu_rsp_ready = 1'b1;
        end
      end
    end
    chk(done, req, "operation completed", done, 1);
    chk(expq.size() == 0, req, "all expected bus transactions seen", expq.size(), 0);
    expq.delete();
  endtask

  task automatic snoop(int cmd, int addr, int wd, string req);
    int idx = addr & 3;
    bit held = (m_st[idx] != 0) && (m_tag[idx] == (addr >> 2));
    bit pend = held && cmd == 1 && m_st[idx] == 3;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(addr);
    #1;
    chk(snp_hit == held, req, "snoop hit", snp_hit, held);
    chk(snp_wb_pend == pend, req, "snoop write-back pending", snp_wb_pend, pend);
    if (pend) begin
      chk(snp_wb_data == DW'(m_dat[idx]), req, "snoop write-back word", snp_wb_data, m_dat[idx]);
      mem[addr] = m_dat[idx];
    end
    if (held) begin
      if (cmd == 1 && m_st[idx] >= 2) m_st[idx] = 1;
      if (cmd >= 2) m_st[idx] = 0;
    end
    if (cmd >= 2) mem[addr] = wd;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'b00;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_tag[i] = 0; m_st[i] = 0; m_dat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R1", "ready after reset", cpu_req_ready, 1);
    chk(bus_req == 1'b0, "R1", "no bus request after reset", bus_req, 0);
    chk(cpu_rsp_valid == 1'b0, "R1", "no response after reset", cpu_rsp_valid, 0);
    snoop(1, 8'h00, 0, "R1");                        // nothing held after reset
    cpu_op(0, 8'h10, 0, 2, 0, "R3");                 // read miss, installs Valid
    cpu_op(0, 8'h10, 0, 0, 0, "R2");                 // read hit, no bus
    cpu_op(1, 8'h10, 16'hA1A1, 3, 0, "R7");          // Valid write -> write-through
    cpu_op(1, 8'h10, 16'hB2B2, 0, 0, "R6");          // Reserved write -> local
    cpu_op(1, 8'h10, 16'hC3C3, 0, 0, "R6");          // Dirty write -> local
    snoop(1, 8'h10, 0, "R4");                        // Dirty supplies write-back
    cpu_op(0, 8'h10, 0, 0, 0, "R2");
    cpu_op(1, 8'h10, 16'hD4D4, 1, 0, "R7");          // Valid again -> write-through
    snoop(1, 8'h10, 0, "R5");                        // Reserved -> Valid
    cpu_op(1, 8'h10, 16'hE5E5, 0, 0, "R5");          // Valid write needs write-through
    snoop(2, 8'h10, 16'h1357, "R8");                 // invalidated
    cpu_op(0, 8'h10, 0, 0, 0, "R8");                 // refetch
    cpu_op(1, 8'h21, 16'h2468, 2, 3, "R9");          // write miss: read + write-through
    cpu_op(1, 8'h21, 16'h369C, 0, 2, "R9");          // ended Reserved: local
    cpu_op(0, 8'h25, 0, 1, 0, "R10");                // Dirty victim written back
    cpu_op(0, 8'h21, 0, 0, 0, "R10");                // Valid victim dropped
    cpu_op(1, 8'h21, 16'h4321, 0, 0, "R10");
    cpu_op(0, 8'h25, 0, 0, 0, "R10");                // Reserved victim dropped
    cpu_op(0, 8'h32, 0, 4, 0, "R3");
    snoop(3, 8'h32, 16'h0F0F, "R8");                 // write-back snoop invalidates
    cpu_op(0, 8'h32, 0, 0, 0, "R8");
    snoop(2, 8'h36, 16'h7777, "R8");                 // different tag: no hit
    cpu_op(0, 8'h32, 0, 0, 0, "R2");
    cpu_op(1, 8'h0B, 16'h5A5A, 0, 1, "R9");
    snoop(1, 8'h0B, 0, "R5");
    cpu_op(1, 8'h0B, 16'h6B6B, 0, 0, "R6");
    cpu_op(1, 8'h0B, 16'h7C7C, 0, 0, "R6");
    snoop(1, 8'h0B, 0, "R4");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule